// File: doc/BRIEF.md
# Fault Classification Replay Controller

This controller sorts a detected software-visible anomaly into one of three fault classes by running up to two rollback-and-replay experiments. When a symptom arrives while it is idle, it asks the rollback logic to restore the last checkpoint on the core that raised the symptom, then asks for a replay on that same core. A clean replay means the fault did not repeat, so it was transient or a non-deterministic software bug. If the symptom comes back, the controller repeats the experiment on a known-good core. A clean run there points to a permanent hardware fault in the first core. A repeat there points to a deterministic software bug or a false positive from a likely-invariant checker, which is handed to software.

Each rollback and each replay is a request held high until its done input is seen. An output selects the target core for the current request. A replay watchdog ends any replay that runs too long and treats it as a symptom. The result is shown for one cycle with a valid flag. A permanent-hardware result also pulses a start strobe for the finer trace-based unit diagnosis.

Top module: `fault_triage_ctrl`

## Requirements
- R1: After reset, rollbackReq, replayReq, targetGood, classValid and traceDiagStart are 0 and classOut is 00.
- R2: A symptomIn high while idle raises rollbackReq on the next cycle with targetGood 0. The cycle after rollbackDone is seen, rollbackReq drops and replayReq rises with the same targetGood.
- R3: If the same-core replay ends with no symptom, the result is class 01 (transient or non-deterministic).
- R4: If the same-core replay ends with a symptom, the controller next raises rollbackReq with targetGood 1, and after that rollback it replays with targetGood 1. No class is reported in between.
- R5: If the good-core replay ends with no symptom, the result is class 11 (permanent hardware), and traceDiagStart is 1 in the same cycle as classValid.
- R6: If the good-core replay ends with a symptom, the result is class 10 (software bug or false positive), and traceDiagStart stays 0.
- R7: classValid is high for exactly one cycle, the cycle after the replay that decides the class ends. classOut is 00 whenever classValid is 0.
- R8: symptomIn is ignored during rollback steps and during the report cycle. It neither restarts the sequence nor changes the class.
- R9: A replay whose done has not arrived after REPLAY_LIMIT cycles with replayReq high is ended by the controller and counted as showing a symptom.
- R10: rollbackReq and replayReq stay high, with targetGood unchanged, until the matching done input is seen.
- R11: A symptom seen at any cycle of a replay counts, including the cycle in which replayDone is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| symptomIn | input | 1 | Anomaly detected on the monitored execution |
| rollbackDone | input | 1 | Rollback logic has restored the checkpoint |
| replayDone | input | 1 | Replay run has completed |
| rollbackReq | output | 1 | Request for a checkpoint rollback, held until done |
| replayReq | output | 1 | Request for a replay, held until done or timeout |
| targetGood | output | 1 | 0: requests target the core that raised the symptom; 1: requests target the known-good core |
| classOut | output | 2 | Fault class: 00 none, 01 transient, 10 software or false positive, 11 permanent hardware |
| classValid | output | 1 | classOut is valid this cycle |
| traceDiagStart | output | 1 | Starts unit-level trace diagnosis on a permanent result |

## Verification
On every cycle the assertions check the handshake hold rule, the one-cycle valid pulse with a zero class around it, the watchdog counter bound, that the good-core phase always opens with a rollback, and that the trace start only goes with a hardware class. Only the bench scenarios show the decision paths. These are which class each combination of replay outcomes yields, that a symptom during rollback or the report cycle is dropped, that a symptom in the same cycle as replayDone counts, and that a stalled replay ends after exactly REPLAY_LIMIT cycles and counts as a symptom.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RB_SAME,
    ST_RP_SAME,
    ST_RB_GOOD,
    ST_RP_GOOD,
    ST_REPORT
  } ftc_state_e;

  typedef enum logic [1:0] {
    CLS_NONE      = 2'b00,
    CLS_TRANSIENT = 2'b01,
    CLS_SOFTWARE  = 2'b10,
    CLS_HARDWARE  = 2'b11
  } ftc_class_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       inReplay;
    logic       loadClass;
    ftc_class_e classSel;
    logic       showReport;
  } ftc_strobe_t;

endpackage

// File: rtl/ftc_datapath.sv
module ftc_datapath
  import ftc_pkg::*;
#(
  parameter int REPLAY_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ftc_strobe_t strobe,
  input  logic        symptomIn,
  input  logic        replayDone,
  output logic        replayEnd,
  output logic        replaySymptom,
  output logic [1:0]  classOut,
  output logic        classValid,
  output logic        traceDiagStart
);

  localparam int CW = $clog2(REPLAY_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(REPLAY_LIMIT - 1);

  logic [CW-1:0] wdCnt;
  logic          symFlag;
  logic          timeout;
  ftc_class_e    classReg;

  assign timeout = strobe.inReplay && (wdCnt == LAST);

  // watchdog counter, cleared whenever no replay is running
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.inReplay) wdCnt <= '0;
    else if (!timeout)             wdCnt <= wdCnt + 1'b1;
  end

  // sticky symptom seen during the current replay
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.inReplay) symFlag <= 1'b0;
    else if (symptomIn)            symFlag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 classReg <= CLS_NONE;
    else if (strobe.loadClass) classReg <= strobe.classSel;
  end

  assign replayEnd      = strobe.inReplay && (replayDone || timeout);
  assign replaySymptom  = symFlag || symptomIn || timeout;
  assign classValid     = strobe.showReport;
  assign classOut       = strobe.showReport ? classReg : CLS_NONE;
  assign traceDiagStart = strobe.showReport && (classReg == CLS_HARDWARE);

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inReplay |-> (wdCnt < CW'(REPLAY_LIMIT))); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    classValid |=> !classValid); // R7
  AST_NONE_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    !classValid |-> (classOut == CLS_NONE)); // R7
  AST_TRACE_ONLY_HW: assert property (@(posedge clk) disable iff (!rstN)
    traceDiagStart |-> (classValid && classOut == CLS_HARDWARE)); // R5

endmodule

// File: rtl/ftc_control.sv
module ftc_control
  import ftc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        symptomIn,
  input  logic        rollbackDone,
  input  logic        replayEnd,
  input  logic        replaySymptom,
  output ftc_strobe_t strobe,
  output logic        rollbackReq,
  output logic        replayReq,
  output logic        targetGood
);

  ftc_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext       = state;
    strobe.loadClass = 1'b0;
    strobe.classSel  = CLS_NONE;
    unique case (state)
      ST_IDLE:    if (symptomIn) stateNext = ST_RB_SAME;
      ST_RB_SAME: if (rollbackDone) stateNext = ST_RP_SAME;
      ST_RP_SAME: if (replayEnd) begin
        if (replaySymptom) stateNext = ST_RB_GOOD;
        else begin
          stateNext        = ST_REPORT;
          strobe.loadClass = 1'b1;
          strobe.classSel  = CLS_TRANSIENT;
        end
      end
      ST_RB_GOOD: if (rollbackDone) stateNext = ST_RP_GOOD;
      ST_RP_GOOD: if (replayEnd) begin
        stateNext        = ST_REPORT;
        strobe.loadClass = 1'b1;
        strobe.classSel  = replaySymptom ? CLS_SOFTWARE : CLS_HARDWARE;
      end
      ST_REPORT:  stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  assign strobe.inReplay   = (state == ST_RP_SAME) || (state == ST_RP_GOOD);
  assign strobe.showReport = (state == ST_REPORT);
  assign rollbackReq = (state == ST_RB_SAME) || (state == ST_RB_GOOD);
  assign replayReq   = strobe.inReplay;
  assign targetGood  = (state == ST_RB_GOOD) || (state == ST_RP_GOOD);

  AST_RB_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rollbackReq && !rollbackDone) |=> (rollbackReq && $stable(targetGood))); // R10
  AST_RP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (replayReq && !replayEnd) |=> (replayReq && $stable(targetGood))); // R10
  AST_GOOD_OPENS_WITH_RB: assert property (@(posedge clk) disable iff (!rstN)
    $rose(targetGood) |-> rollbackReq); // R4
  AST_RB_TO_REPLAY: assert property (@(posedge clk) disable iff (!rstN)
    (rollbackReq && rollbackDone) |=> (replayReq && !rollbackReq)); // R2

endmodule

// File: rtl/fault_triage_ctrl.sv
module fault_triage_ctrl
  import ftc_pkg::*;
#(
  parameter int REPLAY_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       symptomIn,
  input  logic       rollbackDone,
  input  logic       replayDone,
  output logic       rollbackReq,
  output logic       replayReq,
  output logic       targetGood,
  output logic [1:0] classOut,
  output logic       classValid,
  output logic       traceDiagStart
);

  ftc_strobe_t strobe;
  logic        replayEnd;
  logic        replaySymptom;

  ftc_control u_control (
    .clk           (clk),
    .rstN          (rstN),
    .symptomIn     (symptomIn),
    .rollbackDone  (rollbackDone),
    .replayEnd     (replayEnd),
    .replaySymptom (replaySymptom),
    .strobe        (strobe),
    .rollbackReq   (rollbackReq),
    .replayReq     (replayReq),
    .targetGood    (targetGood)
  );

  ftc_datapath #(.REPLAY_LIMIT(REPLAY_LIMIT)) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .symptomIn      (symptomIn),
    .replayDone     (replayDone),
    .replayEnd      (replayEnd),
    .replaySymptom  (replaySymptom),
    .classOut       (classOut),
    .classValid     (classValid),
    .traceDiagStart (traceDiagStart)
  );

endmodule

// File: tb/fault_triage_ctrl_tb.sv
module fault_triage_ctrl_tb;

  localparam int LIMIT = 16;

  logic clk = 1'b0;
  logic rstN, symptomIn, rollbackDone, replayDone;
  logic rollbackReq, replayReq, targetGood, classValid, traceDiagStart;
  logic [1:0] classOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fault_triage_ctrl #(.REPLAY_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .symptomIn(symptomIn),
    .rollbackDone(rollbackDone), .replayDone(replayDone),
    .rollbackReq(rollbackReq), .replayReq(replayReq), .targetGood(targetGood),
    .classOut(classOut), .classValid(classValid), .traceDiagStart(traceDiagStart)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R2: idle symptom launches a same-core rollback
  task automatic startDiag();
    symptomIn = 1'b1; step(); symptomIn = 1'b0;
    chk("R2", "rollbackReq after symptom", rollbackReq, 1);
    chk("R2", "targetGood first rollback", targetGood, 0);
    chk("R2", "replayReq during rollback", replayReq, 0);
  endtask

  // R10 hold, R8 noise during rollback, R2/R4 move to replay
  task automatic doRollback(input bit good, input int waitCyc, input bit noise);
    for (int i = 0; i < waitCyc; i++) begin
      symptomIn = noise; step();
      chk("R10", "rollbackReq held", rollbackReq, 1);
      chk("R10", "targetGood held", targetGood, good);
    end
    symptomIn = 1'b0; rollbackDone = 1'b1; step(); rollbackDone = 1'b0;
    chk(good ? "R4" : "R2", "replayReq after rollback", replayReq, 1);
    chk("R2", "rollbackReq dropped", rollbackReq, 0);
    chk(good ? "R4" : "R2", "replay target", targetGood, good);
  endtask

  // mode 0 clean, 1 mid symptom, 2 symptom with done (R11), 3 timeout (R9)
  task automatic doReplay(input int mode);
    case (mode)
      0: begin step(); chk("R10", "replayReq held", replayReq, 1);
               replayDone = 1'b1; step(); replayDone = 1'b0; end
      1: begin symptomIn = 1'b1; step(); symptomIn = 1'b0;
               chk("R10", "replayReq held", replayReq, 1);
               step(); replayDone = 1'b1; step(); replayDone = 1'b0; end
      2: begin step(); symptomIn = 1'b1; replayDone = 1'b1; step();
               symptomIn = 1'b0; replayDone = 1'b0; end
      default: begin
        for (int i = 0; i < LIMIT - 1; i++) begin
          step(); chk("R9", "replay not ended before limit", replayReq, 1);
        end
        step();
        chk("R9", "replay ended at limit", replayReq, 0);
      end
    endcase
    chk("R10", "replayReq dropped", replayReq, 0);
  endtask

  task automatic expectGoodPhase();
    chk("R4", "rollbackReq to good core", rollbackReq, 1);
    chk("R4", "targetGood", targetGood, 1);
    chk("R4", "no class yet", classValid, 0);
  endtask

  task automatic expectReport(input string req, input int cls);
    chk(req, "classValid", classValid, 1);
    chk(req, "classOut", classOut, cls);
    chk(cls == 3 ? "R5" : "R6", "traceDiagStart", traceDiagStart, cls == 3);
    step();
    chk("R7", "classValid one cycle", classValid, 0);
    chk("R7", "classOut none", classOut, 0);
    chk("R7", "back to idle", rollbackReq, 0);
  endtask

  task automatic scenReset();
    chk("R1", "rollbackReq", rollbackReq, 0);
    chk("R1", "replayReq", replayReq, 0);
    chk("R1", "targetGood", targetGood, 0);
    chk("R1", "classValid", classValid, 0);
    chk("R1", "classOut", classOut, 0);
    chk("R1", "traceDiagStart", traceDiagStart, 0);
  endtask

  task automatic scenTransient();
    startDiag(); doRollback(0, 2, 0); doReplay(0);
    expectReport("R3", 1);
  endtask

  task automatic scenHardware();
    startDiag(); doRollback(0, 1, 0); doReplay(1);
    expectGoodPhase(); doRollback(1, 3, 0); doReplay(0);
    expectReport("R5", 3);
  endtask

  task automatic scenSoftware();
    startDiag(); doRollback(0, 0, 0); doReplay(1);
    expectGoodPhase(); doRollback(1, 0, 0); doReplay(1);
    expectReport("R6", 2);
  endtask

  task automatic scenSymAtDone();
    startDiag(); doRollback(0, 1, 0); doReplay(2);
    expectGoodPhase(); doRollback(1, 1, 0); doReplay(2);
    expectReport("R11", 2);
  endtask

  task automatic scenRollbackNoise();
    startDiag(); doRollback(0, 3, 1); doReplay(0);
    expectReport("R8", 1);
  endtask

  task automatic scenTimeouts();
    startDiag(); doRollback(0, 0, 0); doReplay(3);
    expectGoodPhase(); doRollback(1, 0, 0); doReplay(0);
    expectReport("R9", 3);
    startDiag(); doRollback(0, 0, 0); doReplay(1);
    expectGoodPhase(); doRollback(1, 0, 0); doReplay(3);
    expectReport("R9", 2);
  endtask

  task automatic scenReportIgnore();
    startDiag(); doRollback(0, 0, 0); doReplay(0);
    chk("R8", "report reached", classValid, 1);
    symptomIn = 1'b1; step(); symptomIn = 1'b0;
    chk("R8", "report symptom: idle", classValid, 0);
    step();
    chk("R8", "report symptom: no restart", rollbackReq, 0);
    chk("R8", "report symptom: no replay", replayReq, 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0; symptomIn = 1'b0; rollbackDone = 1'b0; replayDone = 1'b0;
    repeat (3) step();
    rstN = 1'b1; step();
    scenReset();
    scenTransient();
    scenHardware();
    scenSoftware();
    scenSymAtDone();
    scenRollbackNoise();
    scenTimeouts();
    scenReportIgnore();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

endmodule